// File: doc/BRIEF.md
# IrDA SIR Infrared Encoder and Decoder

This block sits between a UART core and an optical infrared transceiver. On the transmit side it takes the UART's NRZ serial output and turns each zero bit into one short light pulse. On the receive side it takes the transceiver's active-low pulse train and rebuilds a full-width NRZ stream for the UART receiver. All timing uses the UART's 16x oversampling enable (`tick16`), so the block follows whatever baud rate the UART divisor sets.

A mode input selects infrared operation. When the mode input is low, both directions are plain wires, and the codec's internal state is held idle. The asynchronous reset is released synchronously inside the block.

Top module: `irda_sir_codec`

## Requirements
- R1: With `ir_mode` = 0, `ir_tx_out` equals `tx_nrz` combinationally, and `tick16` has no effect on it.
- R2: With `ir_mode` = 0, `rx_nrz` equals `ir_rx_in` combinationally.
- R3: With `ir_mode` = 1, `ir_tx_out` idles at 0, and a `tx_nrz` level of 1 produces no pulse.
- R4: With `ir_mode` = 1, each tick is given a sub-bit index from 0 to 15. For a zero bit, the output is high after the ticks with index 7, 8 and 9 and low after every other tick, so the pulse lasts exactly 3 ticks.
- R5: The index is 0 on the first tick at which `tx_nrz` differs from its value at the previous tick. Otherwise it is the previous index plus 1, modulo 16. A zero level held for longer than 16 ticks therefore pulses once every 16 ticks.
- R6: With `ir_mode` = 1, `ir_tx_out` and `rx_nrz` change only at clock edges where `tick16` is 1.
- R7: `ir_rx_in` passes through a 2-flop synchronizer. A low level that is seen at two consecutive ticks is accepted, and `rx_nrz` goes low at the edge of the second of those ticks.
- R8: After an acceptance, `rx_nrz` stays low for 16 ticks, counting the accepting tick, and then returns high. Lows accepted during those 16 ticks are ignored, and a line held low is accepted only once.
- R9: A low level seen at fewer than two consecutive ticks never changes `rx_nrz`. This includes glitches that fall between ticks.
- R10: A new acceptance on the tick at which the hold would end restarts the hold, so pulses 16 ticks apart give a continuous low.
- R11: While `ir_mode` = 0, the decoder is forced idle (output 1) and the encoder is forced idle (line treated as high, index 0). On re-entry `rx_nrz` = 1 and `ir_tx_out` = 0, and a `tx_nrz` of 0 at the first tick counts as a bit boundary.
- R12: After reset with `ir_mode` = 1, `ir_tx_out` = 0 and `rx_nrz` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x baud clock enable, one cycle wide |
| ir_mode | input | 1 | 1 = infrared codec active, 0 = pass-through |
| tx_nrz | input | 1 | NRZ serial data from the UART transmitter |
| ir_tx_out | output | 1 | Line to the infrared transmitter (active-high pulse) |
| ir_rx_in | input | 1 | Line from the infrared receiver (active-low pulse) |
| rx_nrz | output | 1 | Rebuilt NRZ data for the UART receiver |

## Verification
The encoder is driven with framed bytes of all zeros, all ones, alternating bits and mixed nibbles. These patterns separate the pulse's position inside a bit from its repetition across a run of zeros. A pseudo-random sweep of bit lengths from 1 to 24 ticks then shows whether the sub-bit index restarts at each level change or drifts. The decoder receives isolated 3-tick pulses, back-to-back pulses, a second pulse inside the hold window, 1-tick lows, glitches shorter than a tick and a long low. Together these separate acceptance from glitch rejection, retrigger from release, and a single edge from a held level. Mode exit in the middle of a hold and in the middle of a zero bit shows that both halves return to idle.

// File: rtl/irda_pkg.sv
package irda_pkg;

  // Default oversampling ratio: number of enable ticks in one bit time.
  parameter int unsigned IR_OSR         = 16;
  // First sub-bit tick of the transmit pulse and its width in ticks (3/16).
  parameter int unsigned IR_PULSE_START = 7;
  parameter int unsigned IR_PULSE_LEN   = 3;
  // Depth of the receive synchronizer.
  parameter int unsigned IR_SYNC_STAGES = 2;

  // Receive low-level qualifier: how many consecutive ticks saw the line low.
  typedef enum logic [1:0] {
    RUN_HIGH = 2'd0,   // line high at last tick
    RUN_ONE  = 2'd1,   // low at exactly one tick so far
    RUN_HELD = 2'd2    // low at two or more consecutive ticks
  } low_run_e;

endpackage

// File: rtl/irda_sync.sv
// Multi-stage flop synchronizer with a selectable reset value.
module irda_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= RST_VAL;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irda_sir_enc.sv
// Transmit half: NRZ in, one centred narrow pulse per zero bit out.
module irda_sir_enc #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned PULSE_START = 7,
  parameter int unsigned PULSE_LEN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic nrz_in,
  output logic pulse_out
);

  localparam int unsigned CW        = $clog2(OSR);
  localparam int unsigned PULSE_END = PULSE_START + PULSE_LEN;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] idx;
  logic          prev_q, prev_d;
  logic          pulse_q, pulse_d;
  logic          bit_edge;
  logic          in_window;

  // Sub-bit index of the current tick: restart on a level change.
  always_comb begin
    bit_edge  = (nrz_in != prev_q);
    idx       = bit_edge ? '0 : cnt_q;
    in_window = (int'(idx) >= int'(PULSE_START)) && (int'(idx) < int'(PULSE_END));
  end

  always_comb begin
    cnt_d   = cnt_q;
    prev_d  = prev_q;
    pulse_d = pulse_q;
    if (!en) begin
      cnt_d   = '0;
      prev_d  = 1'b1;
      pulse_d = 1'b0;
    end else if (tick) begin
      prev_d  = nrz_in;
      cnt_d   = (int'(idx) == int'(OSR) - 1) ? '0 : idx + 1'b1;
      pulse_d = !nrz_in && in_window;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      prev_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      prev_q  <= prev_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_out = pulse_q;

endmodule

// File: rtl/irda_sir_dec.sv
// Receive half: qualified active-low pulse in, full-width zero bit out.
module irda_sir_dec #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic ir_sync,
  output logic nrz_out
);

  import irda_pkg::*;

  localparam int unsigned   CW        = $clog2(OSR);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(OSR - 1);

  low_run_e      run_q, run_d;
  logic [CW-1:0] hold_q, hold_d;
  logic          out_q, out_d;
  logic          accept;
  logic          hold_busy;

  // A low seen at the previous tick and again now starts a zero bit.
  always_comb begin
    accept    = tick && !ir_sync && (run_q == RUN_ONE);
    hold_busy = (hold_q != '0);
  end

  always_comb begin
    run_d  = run_q;
    hold_d = hold_q;
    out_d  = out_q;
    if (!en) begin
      run_d  = RUN_HIGH;
      hold_d = '0;
      out_d  = 1'b1;
    end else if (tick) begin
      if (ir_sync)                 run_d = RUN_HIGH;
      else if (run_q == RUN_HIGH)  run_d = RUN_ONE;
      else                         run_d = RUN_HELD;

      if (accept && !hold_busy) begin
        out_d  = 1'b0;
        hold_d = HOLD_LOAD;
      end else if (hold_busy) begin
        hold_d = hold_q - 1'b1;
      end else begin
        out_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= RUN_HIGH;
      hold_q <= '0;
      out_q  <= 1'b1;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign nrz_out = out_q;

endmodule

// File: rtl/irda_sir_codec.sv
// Top: infrared SIR codec with pass-through when the mode bit is clear.
module irda_sir_codec #(
  parameter int unsigned OSR         = irda_pkg::IR_OSR,
  parameter int unsigned PSTART      = irda_pkg::IR_PULSE_START,
  parameter int unsigned PLEN        = irda_pkg::IR_PULSE_LEN,
  parameter int unsigned SYNC_STAGES = irda_pkg::IR_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ir_mode,
  input  logic tx_nrz,
  output logic ir_tx_out,
  input  logic ir_rx_in,
  output logic rx_nrz
);

  logic rst_sync_n;
  logic rx_sync;
  logic enc_pulse;
  logic dec_nrz;

  // Reset: asserted asynchronously, released on a clock edge.
  irda_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  irda_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (ir_rx_in),
    .q     (rx_sync)
  );

  irda_sir_enc #(.OSR(OSR), .PULSE_START(PSTART), .PULSE_LEN(PLEN)) u_enc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick16),
    .en        (ir_mode),
    .nrz_in    (tx_nrz),
    .pulse_out (enc_pulse)
  );

  irda_sir_dec #(.OSR(OSR)) u_dec (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick16),
    .en      (ir_mode),
    .ir_sync (rx_sync),
    .nrz_out (dec_nrz)
  );

  assign ir_tx_out = ir_mode ? enc_pulse : tx_nrz;
  assign rx_nrz    = ir_mode ? dec_nrz   : ir_rx_in;

endmodule

// File: rtl/irda_sir_codec_chk.sv
// Property checker for irda_sir_codec, attached with bind below.
module irda_sir_codec_chk #(
  parameter int unsigned PLEN = 3
) (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic ir_mode,
  input logic tx_nrz,
  input logic ir_tx_out,
  input logic rx_nrz
);

  localparam int unsigned RW = $clog2(PLEN + 2);

  logic [RW-1:0] hi_run_q;

  // Ticks at which the infrared transmit line was seen high in a row.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_run_q <= '0;
    else if (!ir_mode)         hi_run_q <= '0;
    else if (tick16) begin
      if (!ir_tx_out)          hi_run_q <= '0;
      else if (int'(hi_run_q) <= int'(PLEN)) hi_run_q <= hi_run_q + 1'b1;
    end
  end

  // R4: no transmit pulse lasts longer than the pulse width
  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hi_run_q) <= int'(PLEN));

  // R3: a pulse only starts on a tick that saw a zero data level
  assert_pulse_needs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mode && $past(ir_mode) && $rose(ir_tx_out)) |-> ($past(tick16) && !$past(tx_nrz)));

  // R6: transmit line steady between ticks in infrared mode
  assert_tx_tick_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mode && $past(ir_mode) && !$past(tick16)) |-> $stable(ir_tx_out));

  // R6: receive output steady between ticks in infrared mode
  assert_rx_tick_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mode && $past(ir_mode) && !$past(tick16)) |-> $stable(rx_nrz));

  // R11: both halves are idle on entering infrared mode
  assert_idle_on_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_mode) |-> (rx_nrz && !ir_tx_out));

endmodule

bind irda_sir_codec irda_sir_codec_chk #(.PLEN(PLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick16    (tick16),
  .ir_mode   (ir_mode),
  .tx_nrz    (tx_nrz),
  .ir_tx_out (ir_tx_out),
  .rx_nrz    (rx_nrz)
);

// File: tb/irda_sir_codec_test.sv
module irda_sir_codec_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n, tick16, ir_mode, tx_nrz, ir_rx_in;
  logic ir_tx_out, rx_nrz;

  int n_cmp = 0;
  int n_bad = 0;

  irda_sir_codec uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .ir_mode(ir_mode),
    .tx_nrz(tx_nrz), .ir_tx_out(ir_tx_out), .ir_rx_in(ir_rx_in), .rx_nrz(rx_nrz)
  );

  // Bench models, written from the requirements.
  logic m_prev;     // tx level at previous tick
  int   m_next;     // index the next non-boundary tick receives
  int   m_run;      // consecutive low ticks on receive (saturates at 2)
  int   m_hold;     // remaining hold ticks
  logic m_out;      // expected decoder output
  string etag, dtag;
  logic last_tx, last_rx;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic models_idle();
    m_prev = 1'b1; m_next = 0; m_run = 0; m_hold = 0; m_out = 1'b1;
  endtask

  // One tick in infrared mode: checks R6 between ticks, then both models.
  task automatic step();
    int idx;
    logic exp_tx;
    bit acc;
    last_tx = ir_tx_out; last_rx = rx_nrz;
    repeat (2) @(negedge clk);
    chk(ir_tx_out, last_tx, "R6 tx between ticks");
    chk(rx_nrz, last_rx, "R6 rx between ticks");
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
    // encoder expectation
    idx = (tx_nrz != m_prev) ? 0 : m_next;
    m_next = (idx + 1) % 16;
    m_prev = tx_nrz;
    exp_tx = (tx_nrz == 1'b0) && (idx >= 7) && (idx <= 9);
    chk(ir_tx_out, exp_tx, (etag != "") ? etag : (tx_nrz ? "R3" : "R4"));
    // decoder expectation
    acc = (ir_rx_in == 1'b0) && (m_run == 1);
    m_run = ir_rx_in ? 0 : ((m_run >= 1) ? 2 : 1);
    if (acc && m_hold == 0) begin m_out = 1'b0; m_hold = 15; end
    else if (m_hold != 0)   m_hold = m_hold - 1;
    else                    m_out = 1'b1;
    chk(rx_nrz, m_out, dtag);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      tx_nrz = fr[i];
      for (int t = 0; t < 16; t++) step();
    end
  endtask

  task automatic rx_level(input logic lvl, input int ticks);
    ir_rx_in = lvl;
    for (int t = 0; t < ticks; t++) step();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick16 = 1'b0; ir_mode = 1'b1; tx_nrz = 1'b1; ir_rx_in = 1'b1;
    etag = ""; dtag = "R7";
    models_idle();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ir_tx_out, 1'b0, "R12 tx after reset");
    chk(rx_nrz, 1'b1, "R12 rx after reset");

    // Encoder: framed byte patterns (R3, R4, R5 for runs of zeros).
    dtag = "R9 rx idle during tx";
    send_byte(8'h00);
    send_byte(8'hFF);
    send_byte(8'h55);
    send_byte(8'hA5);
    send_byte(8'h0F);
    send_byte(8'h3C);
    tx_nrz = 1'b1;
    for (int t = 0; t < 20; t++) step();

    // Encoder: irregular bit lengths, index realignment (R5).
    etag = "R5";
    for (int s = 0; s < 160; s++) begin
      lf = lfsr_next(lf);
      tx_nrz = ~tx_nrz;
      for (int t = 0; t < 1 + int'(lf[4:0]) % 24; t++) step();
    end
    tx_nrz = 1'b1;
    for (int t = 0; t < 20; t++) step();
    etag = "R3";

    // Decoder: isolated 3-tick pulse (R7, R8).
    dtag = "R7 pulse accept";
    rx_level(1'b0, 3);
    dtag = "R8 hold and release";
    rx_level(1'b1, 25);
    // Back-to-back pulses 16 ticks apart (R10).
    dtag = "R10 continuous zeros";
    for (int p = 0; p < 5; p++) begin
      rx_level(1'b0, 3);
      rx_level(1'b1, 13);
    end
    rx_level(1'b1, 20);
    // Second pulse inside the hold window is ignored (R8).
    dtag = "R8 retrigger ignored";
    rx_level(1'b0, 3);
    rx_level(1'b1, 4);
    rx_level(1'b0, 3);
    rx_level(1'b1, 25);
    // One-tick lows are rejected (R9).
    dtag = "R9 one tick low";
    for (int p = 0; p < 4; p++) begin
      rx_level(1'b0, 1);
      rx_level(1'b1, 5);
    end
    // Sub-tick glitch between ticks (R9).
    dtag = "R9 glitch";
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); ir_rx_in = 1'b0;
      @(negedge clk); ir_rx_in = 1'b1;
      for (int t = 0; t < 3; t++) step();
    end
    // Long low is accepted once (R8).
    dtag = "R8 held low";
    rx_level(1'b0, 40);
    rx_level(1'b1, 20);
    // Random low/high runs (R7, R9).
    dtag = "R7 random runs";
    for (int s = 0; s < 150; s++) begin
      lf = lfsr_next(lf);
      rx_level(s[0], 1 + int'(lf[3:0]) % 20);
    end
    rx_level(1'b1, 20);

    // Leave infrared mode mid-hold and mid zero bit (R11).
    dtag = "R11 mode exit";
    rx_level(1'b0, 3);
    tx_nrz = 1'b0;
    for (int t = 0; t < 5; t++) step();
    @(negedge clk);
    ir_mode = 1'b0;
    // Pass-through, all input combinations (R1, R2).
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      tx_nrz = c[0]; ir_rx_in = c[1];
      #2;
      chk(ir_tx_out, c[0], "R1 pass-through");
      chk(rx_nrz, c[1], "R2 pass-through");
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      chk(ir_tx_out, c[0], "R1 tick ignored");
      chk(rx_nrz, c[1], "R2 tick ignored");
    end
    @(negedge clk);
    ir_rx_in = 1'b1; tx_nrz = 1'b0;
    repeat (3) @(negedge clk);
    ir_mode = 1'b1;
    models_idle();
    #2;
    chk(rx_nrz, 1'b1, "R11 rx idle on entry");
    chk(ir_tx_out, 1'b0, "R11 tx idle on entry");
    etag = "R11 boundary on entry";
    for (int t = 0; t < 40; t++) step();
    tx_nrz = 1'b1;
    for (int t = 0; t < 20; t++) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule